// File: doc/BRIEF.md
# Auxiliary System Control Register File

This block holds a small set of platform control registers behind a simple byte-lane register bus: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a 32-bit system-control word. Software uses it to enable a power-fail interrupt, acknowledge that interrupt, ask for a power-down, ask for a system restart and fire the terminal-count strobe of a floppy controller. The block does not carry out these actions. It only produces one-cycle request pulses and a level interrupt for the logic that does.

An external power-failing signal enters asynchronously. It goes through a synchronizer, and the block watches the synchronized value for transitions. A rising transition while the interrupt enable is set latches a status bit. Any other transition clears that bit. The interrupt output is the AND of the status bit and the enable bit. Software may clear the status bit but can never set it.

A bus access takes effect only when its byte-lane mask matches the register's size. Writes with the wrong mask change nothing, and reads with the wrong mask return zero. Reads are combinational in the cycle the read request is presented. Writes take effect at the next clock edge.

Top module: `aux_ctl_regfile`

## Requirements
- R1: `irq_o` is high exactly when the power-fail status (bit 5 of the register at address 4) and the interrupt enable (bit 3 of the register at address 0) are both set. It follows any change of either bit on the cycle after the clock edge that makes the change.
- R2: `pf_in` passes through two synchronizing flops. When the synchronized value changes, the status bit is loaded at the following clock edge. It becomes 1 when the new value is 1 and the enable bit held before that edge is 1, and it becomes 0 in every other case.
- R3: A write to address 4 stores only data bits 1:0 into register bits 1:0. Bit 5 keeps its status value, so software writes cannot set it, and every other bit reads 0.
- R4: A write to address 4 with data bit 1 set clears the status bit. A write to address 4 with data bit 0 set raises `shutdown_req_o` for exactly one cycle after the write edge.
- R5: A write to address 6 with data bit 0 set loads that register with 0x00000002 and raises `sys_reset_req_o` for one cycle. A write to address 6 with bit 0 clear stores the data as written.
- R6: A write to address 3 stores the byte. When data bit 0 is set, it also raises `fd_tc_o` for exactly one cycle after the write edge.
- R7: Reset clears the registers at addresses 0, 2, 3 and 4 (including the status bit) and drives all four outputs low.
- R8: The registers at address 1 (diagnostic), 5 (LED) and 6 (system control) keep their contents through reset.
- R9: The byte registers at addresses 0 to 4 need lane mask 4'b0001 with data in bits 7:0. The LED at address 5 needs 4'b0011. System control at address 6 needs 4'b1111. A write with any other mask is ignored, and a read with any other mask, or a read at address 7, returns 0.
- R10: When a synchronized input transition and a status-clearing write to address 4 fall on the same edge, the transition rule of R2 decides the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_be | input | 4 | Byte-lane mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pf_in | input | 1 | Asynchronous power-failing indication |
| irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| shutdown_req_o | output | 1 | Power-down request pulse |
| sys_reset_req_o | output | 1 | System restart request pulse |

## Verification
The bench aims at the status bit's transition-driven update. It raises the input while the enable is clear and then sets the enable afterwards; a design that sampled the input as a level would raise the interrupt there. It also makes a status-clearing write land on the same edge as a rising transition; a design that let the write win would lose the interrupt. Masked writes to address 4 check that software cannot forge the status bit. A mid-run reset checks that the diagnostic, LED and system-control contents survive; a design that reset them would read back zero. Wrong-lane accesses check that nothing is stored or returned; a loose decode would corrupt registers or return stale data.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int NREG   = 7;

  typedef enum logic [ADDR_W-1:0] {
    RG_CFG   = 3'd0,
    RG_DIAG  = 3'd1,
    RG_MODEM = 3'd2,
    RG_AUX1  = 3'd3,
    RG_AUX2  = 3'd4,
    RG_LED   = 3'd5,
    RG_SYS   = 3'd6
  } reg_idx_e;

  localparam int CFG_PIE_BIT = 3;
  localparam int PS_OFF_BIT  = 0;
  localparam int PS_CLR_BIT  = 1;
  localparam int TC_BIT      = 0;
  localparam int SYS_RST_BIT = 0;
  localparam logic [DATA_W-1:0] SYS_RST_VAL = DATA_W'(2);

  // Lane mask that a register of the given index demands
  function automatic logic [BE_W-1:0] lanes_for(input int idx);
    if (idx == int'(RG_LED))      lanes_for = BE_W'((1 << (HALF_W / BYTE_W)) - 1);
    else if (idx == int'(RG_SYS)) lanes_for = {BE_W{1'b1}};
    else                          lanes_for = BE_W'(1);
  endfunction
endpackage

// File: rtl/aux_ctl_sync.sv
module aux_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/aux_ctl_access.sv
module aux_ctl_access
  import aux_ctl_pkg::*;
(
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BE_W-1:0] NEED = lanes_for(i);
    logic sel;
    assign sel       = bus_valid && (bus_addr == ADDR_W'(i)) && (bus_be == NEED);
    assign wr_hit[i] = sel && bus_write;
    assign rd_hit[i] = sel && !bus_write;
  end
endmodule

// File: rtl/aux_ctl_pwrfail.sv
module aux_ctl_pwrfail (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_sync,
  input  logic en,
  input  logic clr_wr,
  output logic stat,
  output logic evt
);
  logic prev_q, stat_q, stat_d;

  assign evt = pf_sync ^ prev_q;

  always_comb begin
    stat_d = stat_q;
    if (evt)         stat_d = pf_sync & en;
    else if (clr_wr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= pf_sync;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/aux_ctl_regfile.sv
module aux_ctl_regfile
  import aux_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pf_in,
  output logic              irq_o,
  output logic              fd_tc_o,
  output logic              shutdown_req_o,
  output logic              sys_reset_req_o
);
  localparam int I_CFG = int'(RG_CFG);
  localparam int I_DIAG = int'(RG_DIAG);
  localparam int I_MOD = int'(RG_MODEM);
  localparam int I_AUX1 = int'(RG_AUX1);
  localparam int I_AUX2 = int'(RG_AUX2);
  localparam int I_LED = int'(RG_LED);
  localparam int I_SYS = int'(RG_SYS);

  logic [NREG-1:0] wr_hit, rd_hit;
  logic            pf_sync, pf_stat, pf_evt;

  logic [BYTE_W-1:0] cfg_q, cfg_d, mod_q, mod_d, aux1_q, aux1_d, diag_q;
  logic [1:0]        aux2_q, aux2_d;
  logic [HALF_W-1:0] led_q;
  logic [DATA_W-1:0] sys_q, sys_d, rdata_d;
  logic              tc_q, tc_d, sd_q, sd_d, rr_q, rr_d;

  aux_ctl_access u_acc (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  aux_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pf_in), .q(pf_sync)
  );

  aux_ctl_pwrfail u_pf (
    .clk(clk), .rst_n(rst_n), .pf_sync(pf_sync), .en(cfg_q[CFG_PIE_BIT]),
    .clr_wr(wr_hit[I_AUX2] && bus_wdata[PS_CLR_BIT]),
    .stat(pf_stat), .evt(pf_evt)
  );

  // Next-state for the registers cleared by reset
  always_comb begin
    cfg_d  = wr_hit[I_CFG]  ? bus_wdata[BYTE_W-1:0] : cfg_q;
    mod_d  = wr_hit[I_MOD]  ? bus_wdata[BYTE_W-1:0] : mod_q;
    aux1_d = wr_hit[I_AUX1] ? bus_wdata[BYTE_W-1:0] : aux1_q;
    aux2_d = wr_hit[I_AUX2] ? bus_wdata[1:0]        : aux2_q;
    tc_d   = wr_hit[I_AUX1] && bus_wdata[TC_BIT];
    sd_d   = wr_hit[I_AUX2] && bus_wdata[PS_OFF_BIT];
    rr_d   = wr_hit[I_SYS]  && bus_wdata[SYS_RST_BIT];
    sys_d  = bus_wdata[SYS_RST_BIT] ? SYS_RST_VAL : bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mod_q  <= '0;
      aux1_q <= '0;
      aux2_q <= '0;
      tc_q   <= 1'b0;
      sd_q   <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      mod_q  <= mod_d;
      aux1_q <= aux1_d;
      aux2_q <= aux2_d;
      tc_q   <= tc_d;
      sd_q   <= sd_d;
      rr_q   <= rr_d;
    end
  end

  // Registers that survive reset: clock-enabled, no reset term
  always_ff @(posedge clk) begin
    if (wr_hit[I_DIAG]) diag_q <= bus_wdata[BYTE_W-1:0];
    if (wr_hit[I_LED])  led_q  <= bus_wdata[HALF_W-1:0];
    if (wr_hit[I_SYS])  sys_q  <= sys_d;
  end

  always_comb begin
    rdata_d = '0;
    if (rd_hit[I_CFG])  rdata_d = DATA_W'(cfg_q);
    if (rd_hit[I_DIAG]) rdata_d = DATA_W'(diag_q);
    if (rd_hit[I_MOD])  rdata_d = DATA_W'(mod_q);
    if (rd_hit[I_AUX1]) rdata_d = DATA_W'(aux1_q);
    if (rd_hit[I_AUX2]) rdata_d = DATA_W'({pf_stat, 3'b000, aux2_q});
    if (rd_hit[I_LED])  rdata_d = DATA_W'(led_q);
    if (rd_hit[I_SYS])  rdata_d = sys_q;
  end

  assign bus_rdata       = rdata_d;
  assign irq_o           = pf_stat & cfg_q[CFG_PIE_BIT];
  assign fd_tc_o         = tc_q;
  assign shutdown_req_o  = sd_q;
  assign sys_reset_req_o = rr_q;
endmodule

// File: rtl/aux_ctl_chk.sv
module aux_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [2:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        irq_o,
  input logic        fd_tc_o,
  input logic        shutdown_req_o,
  input logic        sys_reset_req_o,
  input logic        pf_evt
);
  logic wr_cfg, wr_aux1, wr_aux2, wr_sys;
  assign wr_cfg  = bus_valid && bus_write && bus_addr == 3'd0 && bus_be == 4'b0001;
  assign wr_aux1 = bus_valid && bus_write && bus_addr == 3'd3 && bus_be == 4'b0001;
  assign wr_aux2 = bus_valid && bus_write && bus_addr == 3'd4 && bus_be == 4'b0001;
  assign wr_sys  = bus_valid && bus_write && bus_addr == 3'd6 && bus_be == 4'b1111;

  // R1: dropping the enable silences the interrupt next cycle
  p_enable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !bus_wdata[3]) |=> !irq_o);

  // R4: clear write without a concurrent input transition drops the interrupt
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux2 && bus_wdata[1] && !pf_evt) |=> !irq_o);

  // R4: power-down pulse only follows a qualifying write
  p_shutdown_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req_o |-> $past(wr_aux2 && bus_wdata[0]));

  // R5: restart pulse only follows a qualifying write
  p_restart_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req_o |-> $past(wr_sys && bus_wdata[0]));

  // R6: terminal-count pulse only follows a qualifying write
  p_tc_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fd_tc_o |-> $past(wr_aux1 && bus_wdata[0]));
endmodule

bind aux_ctl_regfile aux_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .fd_tc_o(fd_tc_o), .shutdown_req_o(shutdown_req_o),
  .sys_reset_req_o(sys_reset_req_o), .pf_evt(pf_evt)
);

// File: tb/tb_aux_ctl_regfile.sv
module tb_aux_ctl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pf_in = 1'b0;
  logic        irq_o, fd_tc_o, shutdown_req_o, sys_reset_req_o;

  int n_chk = 0, n_fail = 0;
  bit run = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  aux_ctl_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pf_in(pf_in), .irq_o(irq_o), .fd_tc_o(fd_tc_o),
    .shutdown_req_o(shutdown_req_o), .sys_reset_req_o(sys_reset_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: history of input samples and register images
  int  hist[3];
  bit  m_stat = 0, m_tc = 0, m_sd = 0, m_rr = 0;
  int  m_cfg = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (hist[k]) hist[k] = 0;
      m_stat = 0; m_tc = 0; m_sd = 0; m_rr = 0; m_cfg = 0;
    end else begin
      bit wr, w_cfg, w_aux1, w_aux2, w_sys, changed;
      int seen;
      wr     = bus_valid && bus_write;
      w_cfg  = wr && bus_addr == 0 && bus_be == 4'b0001;
      w_aux1 = wr && bus_addr == 3 && bus_be == 4'b0001;
      w_aux2 = wr && bus_addr == 4 && bus_be == 4'b0001;
      w_sys  = wr && bus_addr == 6 && bus_be == 4'b1111;
      seen    = hist[1];
      changed = (hist[1] != hist[2]);
      if (changed)                        m_stat = (seen == 1) && m_cfg[3];
      else if (w_aux2 && bus_wdata[1])    m_stat = 0;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = int'(pf_in);
      m_tc = w_aux1 && bus_wdata[0];
      m_sd = w_aux2 && bus_wdata[0];
      m_rr = w_sys && bus_wdata[0];
      if (w_cfg) m_cfg = int'(bus_wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk("R1 irq", 32'(irq_o), 32'(m_stat && m_cfg[3]));
      chk("R6 tc pulse", 32'(fd_tc_o), 32'(m_tc));
      chk("R4 shutdown pulse", 32'(shutdown_req_o), 32'(m_sd));
      chk("R5 restart pulse", 32'(sys_reset_req_o), 32'(m_rr));
    end
  end

  task automatic bw(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a[2:0]; bus_be = be; bus_wdata = d;
    @(negedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_addr = a[2:0]; bus_be = be;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1 bus_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    idle(2);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    run = 1'b1;
    // R7: reset state
    rd(0, 4'b0001, 32'h0, "R7 cfg after reset");
    rd(2, 4'b0001, 32'h0, "R7 modem after reset");
    rd(3, 4'b0001, 32'h0, "R7 aux1 after reset");
    rd(4, 4'b0001, 32'h0, "R7 aux2 after reset");
    // R9: lane mask decode
    bw(0, 4'b0011, 32'h08);
    rd(0, 4'b0001, 32'h0, "R9 wrong-mask write ignored");
    bw(0, 4'b0001, 32'h08);
    rd(0, 4'b1111, 32'h0, "R9 wrong-mask read zero");
    rd(0, 4'b0001, 32'h08, "R9 byte read");
    rd(7, 4'b0001, 32'h0, "R9 unmapped read zero");
    // R1/R2: rising input with enable set
    #1 pf_in = 1'b1;
    idle(6);
    chk("R2 status latched", 32'(irq_o), 32'h1);
    bw(0, 4'b0001, 32'h00);
    chk("R1 enable cleared", 32'(irq_o), 32'h0);
    bw(0, 4'b0001, 32'h08);
    chk("R1 enable restored", 32'(irq_o), 32'h1);
    // R3: status cannot be written, only low two bits stored
    bw(4, 4'b0001, 32'hFC);
    rd(4, 4'b0001, 32'h20, "R3 masked write keeps status");
    // R4: clear and power-down
    bw(4, 4'b0001, 32'h02);
    rd(4, 4'b0001, 32'h02, "R4 status cleared");
    chk("R4 irq after clear", 32'(irq_o), 32'h0);
    bw(4, 4'b0001, 32'h01);
    rd(4, 4'b0001, 32'h01, "R4 power-down bit stored");
    // R2: transitions while disabled never set status
    #1 pf_in = 1'b0;
    idle(6);
    bw(0, 4'b0001, 32'h00);
    #1 pf_in = 1'b1;
    idle(6);
    rd(4, 4'b0001, 32'h01, "R2 rise while disabled");
    bw(0, 4'b0001, 32'h08);
    idle(3);
    chk("R2 no level sampling", 32'(irq_o), 32'h0);
    #1 pf_in = 1'b0;
    idle(6);
    #1 pf_in = 1'b1;
    idle(6);
    rd(4, 4'b0001, 32'h21, "R2 rise while enabled");
    #1 pf_in = 1'b0;
    idle(6);
    rd(4, 4'b0001, 32'h01, "R2 fall clears status");
    // R10: transition and clear on the same edge
    #1 pf_in = 1'b1;
    @(negedge clk);
    bw(4, 4'b0001, 32'h02);
    rd(4, 4'b0001, 32'h22, "R10 transition beats clear");
    chk("R10 irq held", 32'(irq_o), 32'h1);
    bw(4, 4'b0001, 32'h02);
    rd(4, 4'b0001, 32'h02, "R4 later clear");
    // R6: terminal count
    bw(3, 4'b0001, 32'h01);
    bw(3, 4'b0001, 32'h04);
    rd(3, 4'b0001, 32'h04, "R6 aux1 stored");
    bw(3, 4'b0011, 32'h01);
    rd(3, 4'b0001, 32'h04, "R9 aux1 wrong mask");
    // R5: system control
    bw(6, 4'b1111, 32'h12345670);
    rd(6, 4'b1111, 32'h12345670, "R5 plain store");
    bw(6, 4'b1111, 32'hFFFF0001);
    rd(6, 4'b1111, 32'h00000002, "R5 restart status value");
    bw(6, 4'b0011, 32'h0);
    rd(6, 4'b1111, 32'h00000002, "R9 sys wrong mask");
    // R7/R8: reset retention
    #1 pf_in = 1'b0;
    bw(1, 4'b0001, 32'h5A);
    bw(5, 4'b0011, 32'hBEEF);
    bw(6, 4'b1111, 32'hCAFE0000);
    bw(2, 4'b0001, 32'h33);
    bw(3, 4'b0001, 32'h80);
    idle(4);
    do_reset();
    rd(1, 4'b0001, 32'h5A, "R8 diag kept");
    rd(5, 4'b0011, 32'hBEEF, "R8 led kept");
    rd(6, 4'b1111, 32'hCAFE0000, "R8 sys kept");
    rd(5, 4'b0001, 32'h0, "R9 led byte read zero");
    rd(2, 4'b0001, 32'h0, "R7 modem cleared");
    rd(0, 4'b0001, 32'h0, "R7 cfg cleared");
    rd(3, 4'b0001, 32'h0, "R7 aux1 cleared");
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule